// File: doc/BRIEF.md
# UART transmitter with flow control

This block is the transmit half of an asynchronous serial port. Software or a DMA engine writes characters into a small transmit queue. The block serialises each character onto a single line as a start bit, then 7, 8 or 9 data bits sent least significant bit first, an optional odd or even parity bit, and one or two stop bits. Bit timing comes from an external oversample tick enable. A programmable number of ticks makes up one bit.

The block decides whether to start the next character only at a character boundary. Three conditions hold off that start: automatic clear-to-send flow control, a transmit-off control, and a break command. A character already on the line always runs to its last stop bit. Break forces the line low at once. An RS-485 driver-enable output goes high one bit time before the first start bit. It stays high across back-to-back characters and drops after the last stop bit. Single-cycle events report when the queue fill falls to a threshold, when a character ends with nothing queued behind it, and when the synchronised clear-to-send level changes.

Top module: `uart_tx_flow`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then the stop bits at high level. data_bits selects the width: 2'b00 gives 7 bits, 2'b10 gives 9 bits, and 2'b01 or 2'b11 give 8 bits. Every bit lasts osr_m1+1 ticks. An osr_m1 below 4 is treated as 4.
- R2: With par_en high, a parity bit follows the data bits. It is chosen so that the count of ones over the data and parity bits is even when par_odd is 0 and odd when par_odd is 1.
- R3: two_stop high sends two stop bits; low sends one.
- R4: The queue holds 4 characters. fifo_cnt reports the fill and fifo_full is high at 4. A write while full is dropped and leaves the fill and the queued data unchanged.
- R5: lvl_evt is high for one cycle, in the cycle after the fill drops from lvl_thr+1 to lvl_thr.
- R6: With auto_cts high and the synchronised cts_n high, no new character starts, and a character already started completes. With auto_cts low, cts_n has no effect on transmission.
- R7: While tx_off is high, no new character starts, and a character already started completes.
- R8: brk high drives txd low in the same cycle and holds off the start of new characters.
- R9: de rises together with one high lead bit before the first start bit. It stays high with no gap between back-to-back characters and falls after the last stop bit. When de is low and brk is low, txd is high.
- R10: urun_evt is high for one cycle, in the cycle after a final stop bit ends with the queue empty.
- R11: cts_n passes through two reset-high flip-flops. dcts_evt is high for one cycle whenever the synchronised value changes.
- R12: After reset, txd is 1, de is 0, the queue is empty, and all events are 0.
- R13: The format (width, parity, stop bits, oversample ratio) is captured when a character leaves the queue. A format change while that character is on the line applies only to later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversample tick enable |
| osr_m1 | input | OSR_W | Ticks per bit minus one |
| data_bits | input | 2 | Data width select |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits |
| auto_cts | input | 1 | Automatic flow control enable |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| tx_off | input | 1 | Hold off new characters |
| brk | input | 1 | Force line low |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 9 | Character to queue |
| lvl_thr | input | CW | Fill threshold for lvl_evt |
| fifo_cnt | output | CW | Queue fill |
| fifo_full | output | 1 | Queue full |
| txd | output | 1 | Serial line |
| de | output | 1 | RS-485 driver enable |
| lvl_evt | output | 1 | Fill reached threshold |
| urun_evt | output | 1 | Underrun event |
| dcts_evt | output | 1 | Clear-to-send change event |

## Verification
The bench sends single characters and back-to-back pairs in every width, parity and stop combination. These patterns separate bit-count and parity errors from a missing or extra lead bit between characters. Queue bursts sent while transmission is held off fill the queue past full. Releasing them exposes dropped-write handling, threshold events and the underrun at the end of the drain. The holds are raised during a frame and again while idle, for flow control, transmit-off and break. These patterns separate a gate applied at character boundaries from one that cuts a frame short. Short and long clear-to-send pulses and oversample ratios below the floor exercise the synchroniser and the clamp.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

   localparam int TXF_DW = 9;

   typedef enum logic [2:0] {
      TS_IDLE  = 3'd0,
      TS_LEAD  = 3'd1,
      TS_START = 3'd2,
      TS_DATA  = 3'd3,
      TS_PAR   = 3'd4,
      TS_STOP  = 3'd5
   } txf_state_e;

   // width select: 00 -> 7, 10 -> 9, others -> 8
   function automatic logic [3:0] width_of(input logic [1:0] sel);
      logic [3:0] w;
      unique case (sel)
         2'b00:   w = 4'd7;
         2'b10:   w = 4'd9;
         default: w = 4'd8;
      endcase
      return w;
   endfunction

   function automatic logic [TXF_DW-1:0] data_mask(input logic [3:0] nb);
      logic [TXF_DW-1:0] m;
      for (int i = 0; i < TXF_DW; i++) m[i] = (i < int'(nb));
      return m;
   endfunction

endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
   parameter  int DW    = 9,
   parameter  int DEPTH = 4,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          full
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && (count != '0);
   assign rdata   = mem[rd_ptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

endmodule

// File: rtl/txf_cts_sync.sv
module txf_cts_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_VAL = 1'b1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic delta
);

   logic lvl_w;
   logic prev;

   generate
      if (STAGES == 0) begin : g_bypass
         assign lvl_w = pin;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ff <= {STAGES{IDLE_VAL}};
            end else begin
               ff[0] <= pin;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign lvl_w = ff[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE_VAL;
      else        prev <= lvl_w;
   end

   assign level = lvl_w;
   assign delta = lvl_w ^ prev;

endmodule

// File: rtl/txf_framer.sv
module txf_framer
   import uart_txf_pkg::*;
#(
   parameter int OSR_W     = 4,
   parameter int OSR_FLOOR = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              go,
   input  logic [TXF_DW-1:0] head,
   input  logic [OSR_W-1:0]  osr_m1,
   input  logic [1:0]        data_bits,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              brk,
   output logic              pop,
   output logic              frame_end,
   output logic              txd,
   output logic              de
);

   localparam logic [OSR_W-1:0] LIM_MIN = OSR_W'(OSR_FLOOR - 1);

   txf_state_e        st;
   logic [OSR_W-1:0]  tcnt, lim_q, lim_new;
   logic [3:0]        bidx, nb_q, nb_new;
   logic              par_q, two_q, sidx, pbit;
   logic [TXF_DW-1:0] shreg;
   logic              bit_end, last_stop, idle_go, line;

   assign nb_new    = width_of(data_bits);
   assign lim_new   = (osr_m1 < LIM_MIN) ? LIM_MIN : osr_m1;
   assign bit_end   = tick && (st != TS_IDLE) && (tcnt == lim_q);
   assign last_stop = (st == TS_STOP) && (!two_q || sidx);
   assign frame_end = bit_end && last_stop;
   assign idle_go   = tick && (st == TS_IDLE) && go;
   assign pop       = idle_go || (frame_end && go);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= TS_IDLE;
         tcnt  <= '0;
         lim_q <= LIM_MIN;
         bidx  <= '0;
         nb_q  <= 4'd8;
         par_q <= 1'b0;
         two_q <= 1'b0;
         sidx  <= 1'b0;
         pbit  <= 1'b0;
         shreg <= '0;
      end else if (pop) begin
         shreg <= head;
         nb_q  <= nb_new;
         par_q <= par_en;
         pbit  <= (^(head & data_mask(nb_new))) ^ par_odd;
         two_q <= two_stop;
         lim_q <= lim_new;
         sidx  <= 1'b0;
         bidx  <= '0;
         tcnt  <= '0;
         st    <= idle_go ? TS_LEAD : TS_START;
      end else if (tick && (st != TS_IDLE)) begin
         if (tcnt != lim_q) begin
            tcnt <= tcnt + 1'b1;
         end else begin
            tcnt <= '0;
            unique case (st)
               TS_LEAD:  st <= TS_START;
               TS_START: st <= TS_DATA;
               TS_DATA: begin
                  shreg <= shreg >> 1;
                  if (bidx == nb_q - 4'd1) st <= par_q ? TS_PAR : TS_STOP;
                  else                     bidx <= bidx + 4'd1;
               end
               TS_PAR:   st <= TS_STOP;
               TS_STOP: begin
                  if (!last_stop) sidx <= 1'b1;
                  else            st   <= TS_IDLE;
               end
               default:  st <= TS_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      unique case (st)
         TS_START: line = 1'b0;
         TS_DATA:  line = shreg[0];
         TS_PAR:   line = pbit;
         default:  line = 1'b1;
      endcase
      txd = line & ~brk;
   end

   assign de = (st != TS_IDLE);

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
   import uart_txf_pkg::*;
#(
   parameter  int DEPTH       = 4,
   parameter  int OSR_W       = 4,
   parameter  int OSR_FLOOR   = 5,
   parameter  int SYNC_STAGES = 2,
   localparam int CW          = $clog2(DEPTH + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [OSR_W-1:0]  osr_m1,
   input  logic [1:0]        data_bits,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              two_stop,
   input  logic              auto_cts,
   input  logic              cts_n,
   input  logic              tx_off,
   input  logic              brk,
   input  logic              wr_en,
   input  logic [TXF_DW-1:0] wr_data,
   input  logic [CW-1:0]     lvl_thr,
   output logic [CW-1:0]     fifo_cnt,
   output logic              fifo_full,
   output logic              txd,
   output logic              de,
   output logic              lvl_evt,
   output logic              urun_evt,
   output logic              dcts_evt
);

   initial begin : param_chk
      if (DEPTH < 2)
         $fatal(1, "DEPTH must be at least 2");
      if (OSR_FLOOR < 2 || OSR_FLOOR > (1 << OSR_W))
         $fatal(1, "OSR_FLOOR must fit the oversample counter");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $fatal(1, "SYNC_STAGES must be 0 to 4");
   end

   logic              cts_lvl, hold, go, pop, frame_end, push_ok;
   logic [TXF_DW-1:0] head;

   txf_cts_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (cts_n),
      .level (cts_lvl),
      .delta (dcts_evt)
   );

   txf_fifo #(
      .DW    (TXF_DW),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_en),
      .wdata (wr_data),
      .pop   (pop),
      .rdata (head),
      .count (fifo_cnt),
      .full  (fifo_full)
   );

   assign hold    = tx_off || brk || (auto_cts && cts_lvl);
   assign go      = (fifo_cnt != '0) && !hold;
   assign push_ok = wr_en && !fifo_full;

   txf_framer #(
      .OSR_W     (OSR_W),
      .OSR_FLOOR (OSR_FLOOR)
   ) u_frm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .go        (go),
      .head      (head),
      .osr_m1    (osr_m1),
      .data_bits (data_bits),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .two_stop  (two_stop),
      .brk       (brk),
      .pop       (pop),
      .frame_end (frame_end),
      .txd       (txd),
      .de        (de)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_evt  <= 1'b0;
         urun_evt <= 1'b0;
      end else begin
         lvl_evt  <= pop && !push_ok &&
                     ({1'b0, fifo_cnt} == ({1'b0, lvl_thr} + 1'b1));
         urun_evt <= frame_end && (fifo_cnt == '0);
      end
   end

endmodule

// File: rtl/txf_chk.sv
module txf_chk #(
   parameter int CW = 3
)(
   input logic          clk,
   input logic          rst_n,
   input logic          brk,
   input logic          tx_off,
   input logic          txd,
   input logic          de,
   input logic          urun_evt,
   input logic          lvl_evt,
   input logic [CW-1:0] fifo_cnt,
   input logic [CW-1:0] lvl_thr
);

   // R8
   brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk |-> !txd);

   // R9
   idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!de && !brk) |-> txd);

   // R9
   lead_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(de) && !brk) |-> txd);

   // R7
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de) |-> $past(!tx_off && !brk));

   // R10
   urun_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      urun_evt |-> $past(fifo_cnt == '0));

   // R5
   lvl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_evt |-> (fifo_cnt == $past(lvl_thr)));

endmodule

bind uart_tx_flow txf_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .brk      (brk),
   .tx_off   (tx_off),
   .txd      (txd),
   .de       (de),
   .urun_evt (urun_evt),
   .lvl_evt  (lvl_evt),
   .fifo_cnt (fifo_cnt),
   .lvl_thr  (lvl_thr)
);

// File: tb/sim_uart_tx_flow.sv
`timescale 1ns/1ps
module sim_uart_tx_flow;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [3:0] osr_m1 = 4'd7;
   logic [1:0] data_bits = 2'b01;
   logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
   logic       auto_cts = 1'b0, cts_n = 1'b1, tx_off = 1'b0, brk = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_data = '0;
   logic [2:0] lvl_thr = 3'd0;
   logic [2:0] fifo_cnt;
   logic       fifo_full, txd, de, lvl_evt, urun_evt, dcts_evt;

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   bit    done = 1'b0;
   string cur = "R12";

   always #5 clk = ~clk;

   uart_tx_flow u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .osr_m1(osr_m1),
      .data_bits(data_bits), .par_en(par_en), .par_odd(par_odd),
      .two_stop(two_stop), .auto_cts(auto_cts), .cts_n(cts_n),
      .tx_off(tx_off), .brk(brk), .wr_en(wr_en), .wr_data(wr_data),
      .lvl_thr(lvl_thr), .fifo_cnt(fifo_cnt), .fifo_full(fifo_full),
      .txd(txd), .de(de), .lvl_evt(lvl_evt), .urun_evt(urun_evt),
      .dcts_evt(dcts_evt)
   );

   // tick every second cycle
   always @(posedge clk) tick <= ~tick;

   // ---------------- reference model ----------------
   int m_q[$];
   int m_bits[$];
   int m_tc = 0, m_lim = 4;
   bit m_s0 = 1'b1, m_s1 = 1'b1, m_prev = 1'b1, m_lvl = 1'b0, m_urun = 1'b0;

   task automatic m_load(bit lead);
      int v    = m_q.pop_front();
      int nb   = (data_bits == 2'b00) ? 7 : (data_bits == 2'b10) ? 9 : 8;
      int ones = 0;
      m_bits.delete();
      if (lead) m_bits.push_back(1);
      m_bits.push_back(0);
      for (int i = 0; i < nb; i++) begin
         m_bits.push_back((v >> i) & 1);
         ones += (v >> i) & 1;
      end
      if (par_en) m_bits.push_back((ones % 2) ^ int'(par_odd));
      m_bits.push_back(1);
      if (two_stop) m_bits.push_back(1);
      m_lim = (osr_m1 < 4) ? 4 : int'(osr_m1);
      m_tc  = 0;
   endtask

   task automatic m_step();
      bit idle = (m_bits.size() == 0);
      bit hold = tx_off || brk || (auto_cts && m_s1);
      int n    = m_q.size();
      bit go   = (n != 0) && !hold;
      bit push = wr_en && (n < DEPTH);
      bit pop  = 1'b0;
      bit ur   = 1'b0;
      if (idle) begin
         if (tick && go) pop = 1'b1;
      end else if (tick) begin
         if (m_tc == m_lim) begin
            m_tc = 0;
            void'(m_bits.pop_front());
            if (m_bits.size() == 0) begin
               ur = (n == 0);
               if (go) pop = 1'b1;
            end
         end else begin
            m_tc++;
         end
      end
      if (pop) m_load(idle);
      if (push) m_q.push_back(int'(wr_data));
      m_lvl  = pop && !push && (n == int'(lvl_thr) + 1);
      m_urun = ur;
      m_prev = m_s1;
      m_s1   = m_s0;
      m_s0   = cts_n;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete(); m_bits.delete();
         m_tc = 0; m_lim = 4;
         m_s0 = 1'b1; m_s1 = 1'b1; m_prev = 1'b1;
         m_lvl = 1'b0; m_urun = 1'b0;
      end else begin
         m_step();
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk({"R1/", cur, " txd"}, 32'(txd),
             32'(brk ? 0 : ((m_bits.size() != 0) ? m_bits[0] : 1)));
         chk({"R9/", cur, " de"}, 32'(de), 32'(m_bits.size() != 0));
         chk({"R4/", cur, " fifo_cnt"}, 32'(fifo_cnt), 32'(m_q.size()));
         chk({"R4/", cur, " fifo_full"}, 32'(fifo_full), 32'(m_q.size() == DEPTH));
         chk({"R5/", cur, " lvl_evt"}, 32'(lvl_evt), 32'(m_lvl));
         chk({"R10/", cur, " urun_evt"}, 32'(urun_evt), 32'(m_urun));
         chk({"R11/", cur, " dcts_evt"}, 32'(dcts_evt), 32'(m_s1 ^ m_prev));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got %0d cycles expected finish", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic put(int v);
      wr_data = 9'(v); wr_en = 1'b1;
      step(1);
      wr_en = 1'b0;
   endtask

   task automatic drain();
      int guard = 0;
      while ((m_bits.size() != 0 || m_q.size() != 0) && guard < 20000) begin
         step(1); guard++;
      end
      step(4);
   endtask

   initial begin
      step(3);
      // R12 reset state
      chk("R12 txd", 32'(txd), 1);
      chk("R12 de", 32'(de), 0);
      chk("R12 fifo_cnt", 32'(fifo_cnt), 0);
      chk("R12 events", 32'({lvl_evt, urun_evt, dcts_evt}), 0);
      rst_n = 1'b1;
      step(4);

      cur = "R1";
      put(9'h0A5); put(9'h03C); drain();

      cur = "R2";
      data_bits = 2'b00; par_en = 1'b1; par_odd = 1'b0;
      put(9'h05B); put(9'h07F); drain();
      data_bits = 2'b10; par_odd = 1'b1;
      put(9'h1A5); put(9'h0FF); drain();

      cur = "R3";
      data_bits = 2'b01; par_en = 1'b0; two_stop = 1'b1;
      put(9'h081); put(9'h042); drain();
      two_stop = 1'b0;

      cur = "R13";
      put(9'h0C3); step(40);
      data_bits = 2'b00; par_en = 1'b1; two_stop = 1'b1; osr_m1 = 4'd5;
      put(9'h02D); drain();
      data_bits = 2'b01; par_en = 1'b0; two_stop = 1'b0; osr_m1 = 4'd7;

      cur = "R4";
      lvl_thr = 3'd2; tx_off = 1'b1;
      put(9'h011); put(9'h022); put(9'h033); put(9'h044); put(9'h055); put(9'h066);
      step(50);
      tx_off = 1'b0; drain();

      cur = "R5";
      lvl_thr = 3'd0;
      put(9'h0F0); put(9'h00F); drain();

      cur = "R7";
      put(9'h0AA); put(9'h055); step(30);
      tx_off = 1'b1; step(600);
      tx_off = 1'b0; drain();

      cur = "R6";
      auto_cts = 1'b1; cts_n = 1'b1; step(8);
      put(9'h033); put(9'h0CC); step(300);
      cts_n = 1'b0; step(60);
      cts_n = 1'b1; step(600);
      cts_n = 1'b0; drain();
      auto_cts = 1'b0; cts_n = 1'b1; step(6);
      put(9'h096); drain();
      cts_n = 1'b0; step(6);

      cur = "R8";
      brk = 1'b1; put(9'h066); step(200);
      brk = 1'b0; step(60);
      brk = 1'b1; step(20);
      brk = 1'b0; drain();

      cur = "R1";
      osr_m1 = 4'd1; put(9'h099); drain();
      osr_m1 = 4'd15; put(9'h0E7); drain();
      osr_m1 = 4'd7;

      cur = "R11";
      cts_n = 1'b1; step(1);
      cts_n = 1'b0; step(5);
      cts_n = 1'b1; step(3);
      cts_n = 1'b0; step(6);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule